// File: doc/BRIEF.md
# Load Store Ordering Buffer

This block sits between an out-of-order core and a single-port data cache and decides, every cycle, which memory operation may use the cache port. Stores wait in a small store queue until the core commits them. Loads wait in a load queue and may run ahead of older stores whose addresses are known to differ. A load whose word address equals that of an older queued store never touches the cache: it takes its data from the youngest such store.

Requests arrive on one port in program order, one per cycle, with a store/load select bit. A store may arrive before its address is known. It then reports the slot it occupies (`st_slot`, sampled in the cycle it is pushed), and its address is filled in later through the resolve port. Loads always arrive with their address. Results return in load program order, tagged, two cycles after the load wins arbitration. Both queue depths must be powers of two.

Top module: `ldst_order_buf`

## Requirements
- R1: A load whose address matches no older queued store is sent to the cache and returns the cache word, with `ld_ret_fwd`=0. This holds even while older, uncommitted stores to other addresses are still queued.
- R2: A load whose word address equals that of an older queued store with a known address returns that store's data with `ld_ret_fwd`=1, and no cache read is issued for it.
- R3: Loads leave the load queue in program order, and results appear on `ld_ret_*` in that same order.
- R4: Stores are written to the cache in program order. A store is never written before an older load has left the load queue, and a younger store never forwards to an older load.
- R5: While any store older than the head load has an unresolved address, that load and every younger load are held.
- R6: When a load and a store are both eligible in the same cycle, the load takes the cache port and the store waits.
- R7: A store is written to the cache only after it is committed. Each `st_commit` pulse commits the oldest uncommitted queued store. A pulse is ignored when every queued store is already committed.
- R8: When several older stores match a load, the youngest of them in program order supplies the data.
- R9: Each queue holds 4 entries. `ld_ready` / `st_ready` are low while the respective queue is full, and a request that arrives while its queue is full has no effect.
- R10: A load accepted into an empty, unblocked buffer drives a cache read (`cache_req_valid`=1, `cache_req_we`=0) in the second cycle after the accepting edge. Its result is valid one cycle later. The cache returns read data combinationally in the cycle of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr_ok | input | 1 | Store address known at request time |
| req_addr | input | AW | Word address |
| req_data | input | DW | Store data |
| req_tag | input | TW | Load tag, returned with the result |
| ld_ready | output | 1 | Load queue can accept |
| st_ready | output | 1 | Store queue can accept |
| st_slot | output | log2(SBD) | Slot the next pushed store occupies |
| sa_valid | input | 1 | Resolve a store address |
| sa_slot | input | log2(SBD) | Store slot being resolved |
| sa_addr | input | AW | Resolved address |
| st_commit | input | 1 | Commit the oldest uncommitted store |
| cache_req_valid | output | 1 | Cache access this cycle |
| cache_req_we | output | 1 | 1 = write, 0 = read |
| cache_req_addr | output | AW | Cache word address |
| cache_req_wdata | output | DW | Cache write data |
| cache_rdata | input | DW | Cache read data for the current request |
| ld_ret_valid | output | 1 | Load result valid |
| ld_ret_tag | output | TW | Tag of the returning load |
| ld_ret_data | output | DW | Load data |
| ld_ret_fwd | output | 1 | Result came from the store queue |

## Verification
The hardest state to reach is a load that is blocked behind an unresolved store while a younger store to the load's own address is already committed and waiting. In that state the hold, the no-overtake rule and the no-forward-from-younger rule all bear on the same cycle. The stimulus builds it by pushing an unknown-address store, then a load, then a same-address store. It commits both stores and only then resolves the first store. It then reads the order of operations on the cache port. A full sweep of store and load address pairs covers the forward and bypass cases, and directed sequences fill both queues and present pushes while they are full.

// File: rtl/lsob_pkg.sv
package lsob_pkg;
  typedef enum logic [1:0] {
    PICK_IDLE   = 2'd0,
    PICK_LD_MEM = 2'd1,
    PICK_LD_FWD = 2'd2,
    PICK_ST     = 2'd3
  } pick_e;
endpackage

// File: rtl/lsob_store_q.sv
module lsob_store_q #(
  parameter int AW  = 16,
  parameter int DW  = 32,
  parameter int SBD = 4,
  parameter int LQD = 4,
  localparam int PW = (SBD > 1) ? $clog2(SBD) : 1,
  localparam int CW = PW + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           push,
  input  logic           push_aok,
  input  logic [AW-1:0]  push_addr,
  input  logic [DW-1:0]  push_data,
  input  logic [LQD-1:0] lq_live,
  input  logic [LQD-1:0] lq_drop,
  input  logic           fix_v,
  input  logic [PW-1:0]  fix_idx,
  input  logic [AW-1:0]  fix_addr,
  input  logic           cmt,
  input  logic           pop,
  input  logic [SBD-1:0] probe_mask,
  input  logic [AW-1:0]  probe_addr,
  output logic           probe_hold,
  output logic           probe_hit,
  output logic [DW-1:0]  probe_data,
  output logic           head_go,
  output logic [AW-1:0]  head_addr,
  output logic [DW-1:0]  head_data,
  output logic [PW-1:0]  head_o,
  output logic [PW-1:0]  tail_o,
  output logic [SBD-1:0] live_o,
  output logic [CW-1:0]  cnt_o,
  output logic           full_o
);
  logic [AW-1:0]  addr_q [SBD];
  logic [DW-1:0]  data_q [SBD];
  logic [LQD-1:0] olm_q  [SBD];
  logic [SBD-1:0] live_q, aok_q;
  logic [PW-1:0]  head_q, tail_q;
  logic [CW-1:0]  cnt_q, ncmt_q;
  logic           cmt_ok;

  assign cmt_ok = cmt && (ncmt_q < cnt_q);

  // payload storage, no reset
  always_ff @(posedge clk) begin
    for (int i = 0; i < SBD; i++) begin
      if (push && tail_q == PW'(i)) begin
        addr_q[i] <= push_addr;
        data_q[i] <= push_data;
      end else if (fix_v && fix_idx == PW'(i)) begin
        addr_q[i] <= fix_addr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q <= '0;
      aok_q  <= '0;
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      ncmt_q <= '0;
      for (int i = 0; i < SBD; i++) olm_q[i] <= '0;
    end else begin
      for (int i = 0; i < SBD; i++) begin
        olm_q[i] <= olm_q[i] & ~lq_drop;
        if (fix_v && fix_idx == PW'(i) && live_q[i]) aok_q[i] <= 1'b1;
        if (push && tail_q == PW'(i)) begin
          live_q[i] <= 1'b1;
          aok_q[i]  <= push_aok;
          olm_q[i]  <= lq_live & ~lq_drop;
        end
        if (pop && head_q == PW'(i)) live_q[i] <= 1'b0;
      end
      if (push) tail_q <= tail_q + 1'b1;
      if (pop)  head_q <= head_q + 1'b1;
      cnt_q  <= cnt_q  + CW'(push)   - CW'(pop);
      ncmt_q <= ncmt_q + CW'(cmt_ok) - CW'(pop);
    end
  end

  // address comparison against a load
  logic [SBD-1:0] match, unk;
  logic [PW-1:0]  age [SBD];
  for (genvar g = 0; g < SBD; g++) begin : g_ent
    assign age[g]   = PW'(g) - head_q;
    assign match[g] = probe_mask[g] & live_q[g] & aok_q[g] & (addr_q[g] == probe_addr);
    assign unk[g]   = probe_mask[g] & live_q[g] & ~aok_q[g];
  end

  logic [PW-1:0] best, sel;
  always_comb begin
    probe_hit = 1'b0;
    best      = '0;
    sel       = '0;
    for (int i = 0; i < SBD; i++) begin
      if (match[i] && (!probe_hit || age[i] > best)) begin
        probe_hit = 1'b1;
        best      = age[i];
        sel       = PW'(i);
      end
    end
  end

  assign probe_hold = |unk;
  assign probe_data = data_q[sel];
  assign head_go    = live_q[head_q] && aok_q[head_q] && (ncmt_q != '0) && (olm_q[head_q] == '0);
  assign head_addr  = addr_q[head_q];
  assign head_data  = data_q[head_q];
  assign head_o     = head_q;
  assign tail_o     = tail_q;
  assign live_o     = live_q;
  assign cnt_o      = cnt_q;
  assign full_o     = (cnt_q == CW'(SBD));
endmodule

// File: rtl/lsob_load_q.sv
module lsob_load_q #(
  parameter int AW  = 16,
  parameter int TW  = 4,
  parameter int LQD = 4,
  parameter int SBD = 4,
  localparam int PW = (LQD > 1) ? $clog2(LQD) : 1,
  localparam int CW = PW + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           push,
  input  logic [AW-1:0]  push_addr,
  input  logic [TW-1:0]  push_tag,
  input  logic [SBD-1:0] sb_live,
  input  logic [SBD-1:0] sb_drop,
  input  logic           pop,
  output logic           head_v,
  output logic [PW-1:0]  head_o,
  output logic [AW-1:0]  head_addr,
  output logic [TW-1:0]  head_tag,
  output logic [SBD-1:0] head_mask,
  output logic [LQD-1:0] live_o,
  output logic [CW-1:0]  cnt_o,
  output logic           full_o
);
  logic [AW-1:0]  addr_q [LQD];
  logic [TW-1:0]  tag_q  [LQD];
  logic [SBD-1:0] mask_q [LQD];
  logic [LQD-1:0] live_q;
  logic [PW-1:0]  head_q, tail_q;
  logic [CW-1:0]  cnt_q;

  always_ff @(posedge clk) begin
    for (int i = 0; i < LQD; i++) begin
      if (push && tail_q == PW'(i)) begin
        addr_q[i] <= push_addr;
        tag_q[i]  <= push_tag;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q <= '0;
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      for (int i = 0; i < LQD; i++) mask_q[i] <= '0;
    end else begin
      for (int i = 0; i < LQD; i++) begin
        mask_q[i] <= mask_q[i] & ~sb_drop;
        if (push && tail_q == PW'(i)) begin
          live_q[i] <= 1'b1;
          mask_q[i] <= sb_live & ~sb_drop;
        end
        if (pop && head_q == PW'(i)) live_q[i] <= 1'b0;
      end
      if (push) tail_q <= tail_q + 1'b1;
      if (pop)  head_q <= head_q + 1'b1;
      cnt_q <= cnt_q + CW'(push) - CW'(pop);
    end
  end

  assign head_v    = live_q[head_q];
  assign head_o    = head_q;
  assign head_addr = addr_q[head_q];
  assign head_tag  = tag_q[head_q];
  assign head_mask = mask_q[head_q];
  assign live_o    = live_q;
  assign cnt_o     = cnt_q;
  assign full_o    = (cnt_q == CW'(LQD));
endmodule

// File: rtl/ldst_order_buf.sv
module ldst_order_buf
  import lsob_pkg::*;
#(
  parameter int AW  = 16,
  parameter int DW  = 32,
  parameter int TW  = 4,
  parameter int SBD = 4,
  parameter int LQD = 4,
  localparam int SPW = (SBD > 1) ? $clog2(SBD) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  input  logic           req_store,
  input  logic           req_addr_ok,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_data,
  input  logic [TW-1:0]  req_tag,
  output logic           ld_ready,
  output logic           st_ready,
  output logic [SPW-1:0] st_slot,
  input  logic           sa_valid,
  input  logic [SPW-1:0] sa_slot,
  input  logic [AW-1:0]  sa_addr,
  input  logic           st_commit,
  output logic           cache_req_valid,
  output logic           cache_req_we,
  output logic [AW-1:0]  cache_req_addr,
  output logic [DW-1:0]  cache_req_wdata,
  input  logic [DW-1:0]  cache_rdata,
  output logic           ld_ret_valid,
  output logic [TW-1:0]  ld_ret_tag,
  output logic [DW-1:0]  ld_ret_data,
  output logic           ld_ret_fwd
);
  localparam int LPW = (LQD > 1) ? $clog2(LQD) : 1;
  localparam int SCW = SPW + 1;
  localparam int LCW = LPW + 1;

  logic           sb_full, lq_full, st_push, ld_push;
  logic [SBD-1:0] sb_live, sb_drop;
  logic [LQD-1:0] lq_live, lq_drop;
  logic [SPW-1:0] sb_head, sb_tail;
  logic [LPW-1:0] lq_head;
  logic [SCW-1:0] sb_cnt;
  logic [LCW-1:0] lq_cnt;
  logic           lq_head_v, hold, hit, sb_head_go;
  logic [AW-1:0]  lq_head_addr, sb_head_addr;
  logic [TW-1:0]  lq_head_tag;
  logic [SBD-1:0] lq_head_mask;
  logic [DW-1:0]  fwd_data, sb_head_data;
  logic           ld_go, ld_fwd, ld_mem, st_go;
  pick_e          pick;

  assign st_push = req_valid &&  req_store && !sb_full;
  assign ld_push = req_valid && !req_store && !lq_full;

  lsob_store_q #(.AW(AW), .DW(DW), .SBD(SBD), .LQD(LQD)) u_stq (
    .clk(clk), .rst(rst),
    .push(st_push), .push_aok(req_addr_ok), .push_addr(req_addr), .push_data(req_data),
    .lq_live(lq_live), .lq_drop(lq_drop),
    .fix_v(sa_valid), .fix_idx(sa_slot), .fix_addr(sa_addr),
    .cmt(st_commit), .pop(st_go),
    .probe_mask(lq_head_mask), .probe_addr(lq_head_addr),
    .probe_hold(hold), .probe_hit(hit), .probe_data(fwd_data),
    .head_go(sb_head_go), .head_addr(sb_head_addr), .head_data(sb_head_data),
    .head_o(sb_head), .tail_o(sb_tail), .live_o(sb_live), .cnt_o(sb_cnt), .full_o(sb_full)
  );

  lsob_load_q #(.AW(AW), .TW(TW), .LQD(LQD), .SBD(SBD)) u_ldq (
    .clk(clk), .rst(rst),
    .push(ld_push), .push_addr(req_addr), .push_tag(req_tag),
    .sb_live(sb_live), .sb_drop(sb_drop), .pop(ld_go),
    .head_v(lq_head_v), .head_o(lq_head), .head_addr(lq_head_addr), .head_tag(lq_head_tag),
    .head_mask(lq_head_mask), .live_o(lq_live), .cnt_o(lq_cnt), .full_o(lq_full)
  );

  // arbitration: loads first, stores only when the port is free
  assign ld_go  = lq_head_v && !hold;
  assign ld_fwd = ld_go && hit;
  assign ld_mem = ld_go && !hit;
  assign st_go  = sb_head_go && !ld_mem;

  always_comb begin
    lq_drop = '0;
    sb_drop = '0;
    if (ld_go) lq_drop[lq_head] = 1'b1;
    if (st_go) sb_drop[sb_head] = 1'b1;
    if (ld_mem)      pick = PICK_LD_MEM;
    else if (st_go)  pick = PICK_ST;
    else if (ld_fwd) pick = PICK_LD_FWD;
    else             pick = PICK_IDLE;
  end

  logic          p1_v, p1_fwd;
  logic [TW-1:0] p1_tag;
  logic [DW-1:0] p1_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      cache_req_valid <= 1'b0;
      cache_req_we    <= 1'b0;
      p1_v            <= 1'b0;
      p1_fwd          <= 1'b0;
      ld_ret_valid    <= 1'b0;
      ld_ret_fwd      <= 1'b0;
    end else begin
      cache_req_valid <= (pick == PICK_LD_MEM) || (pick == PICK_ST);
      cache_req_we    <= (pick == PICK_ST);
      p1_v            <= ld_go;
      p1_fwd          <= ld_fwd;
      ld_ret_valid    <= p1_v;
      ld_ret_fwd      <= p1_fwd;
    end
  end

  always_ff @(posedge clk) begin
    case (pick)
      PICK_ST: begin
        cache_req_addr  <= sb_head_addr;
        cache_req_wdata <= sb_head_data;
      end
      PICK_LD_MEM: cache_req_addr <= lq_head_addr;
      default: ;
    endcase
    p1_tag      <= lq_head_tag;
    p1_data     <= fwd_data;
    ld_ret_tag  <= p1_tag;
    ld_ret_data <= p1_fwd ? p1_data : cache_rdata;
  end

  assign ld_ready = !lq_full;
  assign st_ready = !sb_full;
  assign st_slot  = sb_tail;
endmodule

// File: rtl/lsob_chk.sv
module lsob_chk #(
  parameter int SBD = 4,
  parameter int LQD = 4,
  localparam int SCW = ((SBD > 1) ? $clog2(SBD) : 1) + 1,
  localparam int LCW = ((LQD > 1) ? $clog2(LQD) : 1) + 1
) (
  input logic           clk,
  input logic           rst,
  input logic           st_commit,
  input logic           cache_req_valid,
  input logic           cache_req_we,
  input logic           ld_ret_valid,
  input logic           ld_ret_fwd,
  input logic [SCW-1:0] sb_cnt,
  input logic [LCW-1:0] lq_cnt
);
  logic [31:0] cm_n, wr_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      cm_n <= '0;
      wr_n <= '0;
    end else begin
      cm_n <= cm_n + 32'(st_commit);
      wr_n <= wr_n + 32'(cache_req_valid && cache_req_we);
    end
  end

  a_r2_fwd_skips_cache: assert property (@(posedge clk) disable iff (rst)
    ld_ret_valid && ld_ret_fwd |-> !$past(cache_req_valid && !cache_req_we));

  a_r3_mem_ret_has_read: assert property (@(posedge clk) disable iff (rst)
    ld_ret_valid && !ld_ret_fwd |-> $past(cache_req_valid && !cache_req_we));

  a_r7_write_after_commit: assert property (@(posedge clk) disable iff (rst)
    cache_req_valid && cache_req_we |-> wr_n < cm_n);

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
    sb_cnt <= SCW'(SBD) && lq_cnt <= LCW'(LQD));
endmodule

bind ldst_order_buf lsob_chk #(.SBD(SBD), .LQD(LQD)) u_lsob_chk (
  .clk(clk), .rst(rst), .st_commit(st_commit),
  .cache_req_valid(cache_req_valid), .cache_req_we(cache_req_we),
  .ld_ret_valid(ld_ret_valid), .ld_ret_fwd(ld_ret_fwd),
  .sb_cnt(sb_cnt), .lq_cnt(lq_cnt)
);

// File: tb/test_ldst_order_buf.sv
module test_ldst_order_buf;
  localparam int AW = 4, DW = 16, TW = 4, SBD = 4, LQD = 4, SPW = 2;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_store = 0, req_addr_ok = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic [TW-1:0] req_tag = '0;
  logic ld_ready, st_ready;
  logic [SPW-1:0] st_slot;
  logic sa_valid = 0;
  logic [SPW-1:0] sa_slot = '0;
  logic [AW-1:0] sa_addr = '0;
  logic st_commit = 0;
  logic cache_req_valid, cache_req_we;
  logic [AW-1:0] cache_req_addr;
  logic [DW-1:0] cache_req_wdata, cache_rdata;
  logic ld_ret_valid, ld_ret_fwd;
  logic [TW-1:0] ld_ret_tag;
  logic [DW-1:0] ld_ret_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  ldst_order_buf #(.AW(AW), .DW(DW), .TW(TW), .SBD(SBD), .LQD(LQD)) i_ldst_order_buf (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store), .req_addr_ok(req_addr_ok),
    .req_addr(req_addr), .req_data(req_data), .req_tag(req_tag), .ld_ready(ld_ready),
    .st_ready(st_ready), .st_slot(st_slot), .sa_valid(sa_valid), .sa_slot(sa_slot),
    .sa_addr(sa_addr), .st_commit(st_commit), .cache_req_valid(cache_req_valid),
    .cache_req_we(cache_req_we), .cache_req_addr(cache_req_addr),
    .cache_req_wdata(cache_req_wdata), .cache_rdata(cache_rdata),
    .ld_ret_valid(ld_ret_valid), .ld_ret_tag(ld_ret_tag), .ld_ret_data(ld_ret_data),
    .ld_ret_fwd(ld_ret_fwd)
  );

  function automatic logic [DW-1:0] initv(input int i);
    return DW'(16'h0100 * i + 16'h0033);
  endfunction

  // cache model
  logic [DW-1:0] mem [16];
  assign cache_rdata = mem[cache_req_addr];
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 16; i++) mem[i] <= initv(i);
    end else if (cache_req_valid && cache_req_we) begin
      mem[cache_req_addr] <= cache_req_wdata;
    end
  end

  // port monitor
  logic [TW-1:0] r_tag  [256];
  logic [DW-1:0] r_data [256];
  logic          r_fwd  [256];
  logic          o_we   [256];
  logic [AW-1:0] o_addr [256];
  int ret_n = 0, op_n = 0, wr_n = 0;
  always @(negedge clk) begin
    if (!rst && ld_ret_valid) begin
      r_tag[ret_n] = ld_ret_tag; r_data[ret_n] = ld_ret_data; r_fwd[ret_n] = ld_ret_fwd;
      ret_n++;
    end
    if (!rst && cache_req_valid) begin
      o_we[op_n] = cache_req_we; o_addr[op_n] = cache_req_addr;
      op_n++;
      if (cache_req_we) wr_n++;
    end
  end

  int checks = 0, errors = 0;
  logic [DW-1:0] arch [16];
  logic [TW-1:0] tg = '0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic push_ld(input logic [AW-1:0] a);
    req_valid = 1; req_store = 0; req_addr = a; req_tag = tg; tg++;
    tick();
    req_valid = 0;
  endtask

  task automatic push_st(input logic ok, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         output logic [SPW-1:0] slot);
    slot = st_slot;
    req_valid = 1; req_store = 1; req_addr_ok = ok; req_addr = a; req_data = d;
    tick();
    req_valid = 0; req_store = 0; req_addr_ok = 0;
  endtask

  task automatic commit1();
    st_commit = 1; tick(); st_commit = 0;
  endtask

  task automatic resolve(input logic [SPW-1:0] s, input logic [AW-1:0] a);
    sa_valid = 1; sa_slot = s; sa_addr = a; tick(); sa_valid = 0;
  endtask

  task automatic wait_ret(input string req, input int n);
    for (int k = 0; k < 60 && ret_n < n; k++) tick();
    check(req, ret_n, n);
  endtask

  task automatic wait_wr(input string req, input int n);
    for (int k = 0; k < 60 && wr_n < n; k++) tick();
    check(req, wr_n, n);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [SPW-1:0] s0, s1, sx;
    logic [DW-1:0] d;
    int base, ob, wb;
    for (int i = 0; i < 16; i++) arch[i] = initv(i);
    repeat (3) tick();
    rst = 0;
    tick();
    // reset state (R9)
    check("R9 reset ld_ready", ld_ready, 1);
    check("R9 reset st_ready", st_ready, 1);
    check("R10 reset cache_req_valid", cache_req_valid, 0);
    check("R10 reset ld_ret_valid", ld_ret_valid, 0);

    // R10 latency on an idle buffer
    push_ld(4'd2);
    tick();
    check("R10 read at second cycle", {31'd0, cache_req_valid && !cache_req_we}, 1);
    check("R10 read address", cache_req_addr, 2);
    tick();
    check("R10 result one cycle later", ld_ret_valid, 1);
    check("R10 result data", ld_ret_data, arch[2]);
    tick();

    // R1 / R2 / R7 sweep over store and load address pairs
    for (int s = 0; s < 4; s++) begin
      for (int l = 0; l < 4; l++) begin
        d = DW'(16'hA000 + s * 16 + l);
        base = ret_n; wb = wr_n;
        push_st(1'b1, AW'(s), d, s0);
        push_ld(AW'(l));
        wait_ret("R1 R2 sweep return", base + 1);
        if (s == l) begin
          check("R2 forwarded data", r_data[base], d);
          check("R2 forwarded flag", r_fwd[base], 1);
        end else begin
          check("R1 bypass data", r_data[base], arch[l]);
          check("R1 bypass flag", r_fwd[base], 0);
        end
        repeat (3) tick();
        check("R7 no write before commit", wr_n, wb);
        commit1();
        wait_wr("R7 write after commit", wb + 1);
        arch[s] = d;
      end
    end

    // R8 youngest matching store, R4 write order
    base = ret_n; wb = wr_n; ob = op_n;
    push_st(1'b1, 4'd5, 16'h1111, s0);
    push_st(1'b1, 4'd5, 16'h2222, s0);
    push_st(1'b1, 4'd6, 16'h3333, s0);
    push_ld(4'd5);
    wait_ret("R8 return", base + 1);
    check("R8 youngest data", r_data[base], 16'h2222);
    check("R8 forwarded flag", r_fwd[base], 1);
    commit1(); commit1(); commit1();
    wait_wr("R4 three writes", wb + 3);
    check("R4 write order first", {o_we[ob], o_addr[ob]}, {1'b1, 4'd5});
    check("R4 write order third", {o_we[ob+2], o_addr[ob+2]}, {1'b1, 4'd6});
    arch[5] = 16'h2222; arch[6] = 16'h3333;
    base = ret_n;
    push_ld(4'd5);
    wait_ret("R4 readback", base + 1);
    check("R4 cache holds youngest", r_data[base], 16'h2222);

    // R5 unknown address holds loads; resolves to match
    base = ret_n; wb = wr_n;
    push_st(1'b0, 4'd0, 16'h5A5A, s0);
    push_ld(4'd7);
    repeat (6) tick();
    check("R5 load held", ret_n, base);
    resolve(s0, 4'd7);
    wait_ret("R5 release", base + 1);
    check("R5 forwarded after resolve", r_data[base], 16'h5A5A);
    commit1();
    wait_wr("R5 drain", wb + 1);
    arch[7] = 16'h5A5A;
    // resolves to a different address
    base = ret_n; wb = wr_n;
    push_st(1'b0, 4'd0, 16'h6B6B, s0);
    push_ld(4'd7);
    repeat (6) tick();
    check("R5 load held again", ret_n, base);
    resolve(s0, 4'd8);
    wait_ret("R5 release 2", base + 1);
    check("R5 cache data after resolve", r_data[base], arch[7]);
    check("R5 not forwarded", r_fwd[base], 0);
    commit1();
    wait_wr("R5 drain 2", wb + 1);
    arch[8] = 16'h6B6B;

    // R4 younger committed store waits for older held load
    base = ret_n; wb = wr_n;
    push_st(1'b0, 4'd0, 16'hC0C0, s0);
    push_ld(4'd9);
    push_st(1'b1, 4'd9, 16'hC1C1, s1);
    commit1(); commit1();
    repeat (4) tick();
    check("R4 nothing written while load held", wr_n, wb);
    ob = op_n;
    resolve(s0, 4'd10);
    wait_wr("R4 both written", wb + 2);
    check("R4 load sees old value", r_data[base], arch[9]);
    check("R4 no forward from younger", r_fwd[base], 0);
    check("R4 op0 load read", {o_we[ob], o_addr[ob]}, {1'b0, 4'd9});
    check("R4 op1 older store", {o_we[ob+1], o_addr[ob+1]}, {1'b1, 4'd10});
    check("R4 op2 younger store", {o_we[ob+2], o_addr[ob+2]}, {1'b1, 4'd9});
    arch[10] = 16'hC0C0; arch[9] = 16'hC1C1;

    // R6 load priority over committed store
    base = ret_n; wb = wr_n; ob = op_n;
    push_st(1'b1, 4'd11, 16'hD00D, s0);
    st_commit = 1;
    push_ld(4'd12);
    st_commit = 0;
    push_ld(4'd13);
    wait_wr("R6 store written", wb + 1);
    check("R6 first op load", {o_we[ob], o_addr[ob]}, {1'b0, 4'd12});
    check("R6 second op load", {o_we[ob+1], o_addr[ob+1]}, {1'b0, 4'd13});
    check("R6 store last", {o_we[ob+2], o_addr[ob+2]}, {1'b1, 4'd11});
    arch[11] = 16'hD00D;
    wait_ret("R6 returns", base + 2);

    // R3 program order of load results
    base = ret_n;
    for (int i = 0; i < 4; i++) push_ld(AW'(i));
    wait_ret("R3 returns", base + 4);
    for (int i = 0; i < 4; i++) begin
      check("R3 tag order", r_tag[base+i], TW'(tg - 4 + i));
      check("R3 data", r_data[base+i], arch[i]);
    end

    // R9 load queue full
    base = ret_n; wb = wr_n;
    push_st(1'b0, 4'd0, 16'hE0E0, s0);
    for (int i = 0; i < 4; i++) push_ld(AW'(i));
    check("R9 ld_ready low when full", ld_ready, 0);
    req_valid = 1; req_store = 0; req_addr = 4'd1; req_tag = 4'hF;
    tick();
    req_valid = 0;
    resolve(s0, 4'd14);
    wait_ret("R9 four returns", base + 4);
    repeat (5) tick();
    check("R9 dropped load absent", ret_n, base + 4);
    check("R9 last tag", r_tag[base+3], TW'(tg - 1));
    commit1();
    wait_wr("R9 drain", wb + 1);
    arch[14] = 16'hE0E0;

    // R9 store queue full, R7 surplus commit ignored
    wb = wr_n;
    for (int i = 0; i < 4; i++) push_st(1'b1, AW'(i), DW'(16'hF000 + i), sx);
    check("R9 st_ready low when full", st_ready, 0);
    req_valid = 1; req_store = 1; req_addr_ok = 1; req_addr = 4'd15; req_data = 16'hBAD0;
    tick();
    req_valid = 0; req_store = 0; req_addr_ok = 0;
    for (int i = 0; i < 5; i++) commit1();
    wait_wr("R9 four writes", wb + 4);
    repeat (5) tick();
    check("R9 dropped store not written", wr_n, wb + 4);
    for (int i = 0; i < 4; i++) arch[i] = DW'(16'hF000 + i);
    base = ret_n;
    push_ld(4'd15);
    push_ld(4'd3);
    wait_ret("R9 readback", base + 2);
    check("R9 addr 15 unchanged", r_data[base], arch[15]);
    check("R7 committed store visible", r_data[base+1], arch[3]);
    // R7 commit with nothing queued then a store: not written
    wb = wr_n;
    commit1();
    push_st(1'b1, 4'd4, 16'h7777, s0);
    repeat (6) tick();
    check("R7 stale commit ignored", wr_n, wb);
    commit1();
    wait_wr("R7 later commit", wb + 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule